// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds eight one-bit claim tokens that two independent ports, left and right, use to agree on who may touch a shared resource. Software on either side claims a token by writing a 0 to it and gives it back by writing a 1. It learns whether the claim succeeded by reading the token in a later cycle. Every token remembers which port owns it. A port also remembers that it asked for a busy token, and it receives the token as soon as the owner lets it go.

Each port has an active-low semaphore select, an active-low memory chip select, an active-low write strobe, an active-low output enable, a 3-bit token index and a 32-bit data bus. One bit in each byte lane of that bus carries the request. When both ports try to claim the same free token in the same cycle, the left port receives it and the right port's claim stays pending. Read-back is registered and is marked by a one-cycle valid strobe.

Top module: `dp_sema_unit`

## Requirements
- R1: A port makes a semaphore access only when its semaphore select is low and its chip select is high. With both selects low, or with the semaphore select high, the port changes no token and produces no read result.
- R2: The 3-bit index selects one of eight independent tokens, and an access to one token leaves the other seven unchanged.
- R3: The value written is the AND of data bits 0, 8, 16 and 24. A 0 in any of these bits is a claim and all four at 1 is a release. No other data bit has any effect.
- R4: A token that no port owns reads as 32'hFFFF_FFFF from both ports.
- R5: A read access (write strobe high, output enable low) raises the valid strobe and presents the data in the following cycle. The data shows all writes made in earlier cycles, so a read in the cycle right after a claim shows that claim.
- R6: A port reads 32'h0000_0000 on a token it owns, and the other port reads 32'hFFFF_FFFF on that token.
- R7: When both ports claim the same free token in the same cycle, the left port becomes owner and the right port's claim stays pending.
- R8: A release from a port that does not own the token never frees the token. It only withdraws that port's own pending claim.
- R9: When the owner releases a token that the other port has claimed or is claiming, the other port owns it from the next cycle.
- R10: After reset, all tokens are free, no claims are pending and both valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_cs_n | input | 1 | Left memory chip select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 32 | Left write data |
| l_rdata | output | 32 | Left read-back data |
| l_rd_vld | output | 1 | Left read-back valid |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_cs_n | input | 1 | Right memory chip select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 32 | Right write data |
| r_rdata | output | 32 | Right read-back data |
| r_rd_vld | output | 1 | Right read-back valid |

## Verification
The assertions check on every cycle that ownership changes only in the allowed ways. An owner keeps a token until it releases it itself. A same-cycle claim on a free token goes to the left port and leaves the right claim pending. A release while the other port waits hands the token straight over. An illegal select combination leaves all owners unchanged, and a read access always produces a valid strobe one cycle later. Other behaviours can only be shown by the bench's scenarios, which compare read-back values against a scoreboard: the AND of the byte-lane bits, the per-port view of a token, a withdrawn claim leaving the token free, and token isolation.

// File: rtl/dp_sema_pkg.sv
package dp_sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_t;
endpackage

// File: rtl/dp_sema_port_dec.sv
module dp_sema_port_dec #(
  parameter int NFLAGS = 8,
  parameter int AW     = 3,
  parameter int DW     = 32
) (
  input  logic              sel_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic              wr_en,
  output logic              rd_en,
  output logic [NFLAGS-1:0] req,
  output logic [NFLAGS-1:0] rel
);
  localparam int LANES = DW / 8;

  logic             acc;
  logic [LANES-1:0] lane_bits;
  logic             wr_val;

  // One request bit per byte lane, at the lane's lowest bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g] = wdata[8*g];
  end

  always_comb begin
    acc    = !sel_n && cs_n;
    wr_en  = acc && !we_n;
    rd_en  = acc && we_n && !oe_n;
    wr_val = &lane_bits;
  end

  for (genvar f = 0; f < NFLAGS; f++) begin : g_hit
    assign req[f] = wr_en && (addr == AW'(f)) && !wr_val;
    assign rel[f] = wr_en && (addr == AW'(f)) &&  wr_val;
  end
endmodule

// File: rtl/dp_sema_cell.sv
module dp_sema_cell
  import dp_sema_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_l,
  input  logic   rel_l,
  input  logic   req_r,
  input  logic   rel_r,
  output owner_t owner_o
);
  owner_t owner_q, owner_d;
  logic   pend_l_q, pend_l_d;
  logic   pend_r_q, pend_r_d;

  always_comb begin
    owner_d  = owner_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (req_l) begin
          owner_d  = OWN_LEFT;
          pend_r_d = req_r;
        end else if (req_r) begin
          owner_d  = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (rel_l) begin
          owner_d  = (pend_r_q || req_r) ? OWN_RIGHT : OWN_NONE;
          pend_r_d = 1'b0;
        end else if (req_r) begin
          pend_r_d = 1'b1;
        end else if (rel_r) begin
          pend_r_d = 1'b0;
        end
      end
      OWN_RIGHT: begin
        if (rel_r) begin
          owner_d  = (pend_l_q || req_l) ? OWN_LEFT : OWN_NONE;
          pend_l_d = 1'b0;
        end else if (req_l) begin
          pend_l_d = 1'b1;
        end else if (rel_l) begin
          pend_l_d = 1'b0;
        end
      end
      default: begin
        owner_d  = OWN_NONE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign owner_o = owner_q;

  // R8
  left_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && !rel_l) |=> owner_q == OWN_LEFT);
  // R8
  right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RIGHT && !rel_r) |=> owner_q == OWN_RIGHT);
  // R7
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && req_l && req_r) |=> (owner_q == OWN_LEFT && pend_r_q));
  // R9
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && rel_l && pend_r_q) |=> (owner_q == OWN_RIGHT && !pend_r_q));
endmodule

// File: rtl/dp_sema_unit.sv
module dp_sema_unit
  import dp_sema_pkg::*;
#(
  parameter int NFLAGS = 8,
  parameter int AW     = 3,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel_n,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rd_vld,
  input  logic          r_sel_n,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rd_vld
);
  logic              l_wr, l_rd, r_wr, r_rd;
  logic [NFLAGS-1:0] l_req, l_rel, r_req, r_rel;
  owner_t            own [NFLAGS];
  logic [2*NFLAGS-1:0] own_flat;

  dp_sema_port_dec #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_dec_l (
    .sel_n(l_sel_n), .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .addr(l_addr), .wdata(l_wdata),
    .wr_en(l_wr), .rd_en(l_rd), .req(l_req), .rel(l_rel)
  );

  dp_sema_port_dec #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_dec_r (
    .sel_n(r_sel_n), .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .addr(r_addr), .wdata(r_wdata),
    .wr_en(r_wr), .rd_en(r_rd), .req(r_req), .rel(r_rel)
  );

  for (genvar f = 0; f < NFLAGS; f++) begin : g_cell
    dp_sema_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(l_req[f]), .rel_l(l_rel[f]),
      .req_r(r_req[f]), .rel_r(r_rel[f]),
      .owner_o(own[f])
    );
    assign own_flat[2*f +: 2] = own[f];
  end

  // Read-back: a port sees zeros only on a token it owns.
  logic [DW-1:0] l_rdata_d, r_rdata_d;

  always_comb begin
    l_rdata_d = (own[l_addr] == OWN_LEFT)  ? '0 : '1;
    r_rdata_d = (own[r_addr] == OWN_RIGHT) ? '0 : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata  <= '1;
      r_rdata  <= '1;
      l_rd_vld <= 1'b0;
      r_rd_vld <= 1'b0;
    end else begin
      l_rd_vld <= l_rd;
      r_rd_vld <= r_rd;
      if (l_rd) l_rdata <= l_rdata_d;
      if (r_rd) r_rdata <= r_rdata_d;
    end
  end

  // R1
  illegal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_sel_n && !r_wr) |=> $stable(own_flat));
  // R5
  l_rdvld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && l_cs_n && l_we_n && !l_oe_n) |=> l_rd_vld);
  // R5
  r_rdvld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_sel_n && r_cs_n && r_we_n && !r_oe_n) |=> r_rd_vld);
endmodule

// File: tb/dp_sema_unit_bench.sv
`timescale 1ns/1ps
module dp_sema_unit_bench;
  localparam logic [31:0] ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] ZEROS = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        l_sel_n, l_cs_n, l_we_n, l_oe_n;
  logic [2:0]  l_addr;
  logic [31:0] l_wdata, l_rdata;
  logic        l_rd_vld;
  logic        r_sel_n, r_cs_n, r_we_n, r_oe_n;
  logic [2:0]  r_addr;
  logic [31:0] r_wdata, r_rdata;
  logic        r_rd_vld;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] ql[$], qr[$];
  string       tl[$], tr[$];

  always #2.5 clk = ~clk;

  dp_sema_unit u_dp_sema_unit (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rd_vld(l_rd_vld),
    .r_sel_n(r_sel_n), .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rd_vld(r_rd_vld)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one port for the coming clock edge (no wait).
  task automatic drv(input bit p, input logic sel_n, input logic cs_n, input logic we_n,
                     input logic oe_n, input logic [2:0] a, input logic [31:0] d);
    if (!p) begin
      l_sel_n = sel_n; l_cs_n = cs_n; l_we_n = we_n; l_oe_n = oe_n; l_addr = a; l_wdata = d;
    end else begin
      r_sel_n = sel_n; r_cs_n = cs_n; r_we_n = we_n; r_oe_n = oe_n; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic idle(input bit p);
    drv(p, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, ONES);
  endtask

  task automatic wr(input bit p, input logic [2:0] a, input logic [31:0] d);
    drv(p, 1'b0, 1'b1, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input bit p, input logic [2:0] a, input logic [31:0] exp, input string tag);
    drv(p, 1'b0, 1'b1, 1'b1, 1'b0, a, ONES);
    if (!p) begin ql.push_back(exp); tl.push_back(tag); end
    else    begin qr.push_back(exp); tr.push_back(tag); end
  endtask

  task automatic step();
    @(negedge clk);
    idle(1'b0);
    idle(1'b1);
  endtask

  // Monitor: pop expected items as read results appear.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (l_rd_vld) begin
        if (ql.size() == 0) check("R5 left unexpected valid", 32'd1, 32'd0);
        else check(tl.pop_front(), l_rdata, ql.pop_front());
      end
      if (r_rd_vld) begin
        if (qr.size() == 0) check("R5 right unexpected valid", 32'd1, 32'd0);
        else check(tr.pop_front(), r_rdata, qr.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle(1'b0);
    idle(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 left valid after reset", {31'd0, l_rd_vld}, 32'd0);
    check("R10 right valid after reset", {31'd0, r_rd_vld}, 32'd0);

    // R4 / R10: free token reads ones from both ports
    rd(0, 3'd0, ONES, "R4 left free"); rd(1, 3'd0, ONES, "R4 right free"); step(); step();

    // R6 / R5: left claims token 0, reads the very next cycle
    wr(0, 3'd0, ZEROS); step();
    rd(0, 3'd0, ZEROS, "R5 R6 left owns t0"); rd(1, 3'd0, ONES, "R6 right sees owned t0"); step(); step();

    // R2: token 1 untouched
    rd(0, 3'd1, ONES, "R2 left t1 free"); step(); step();

    // R9: right claims t0 (pending), left releases, right owns next cycle
    wr(1, 3'd0, ZEROS); step();
    wr(0, 3'd0, ONES); step();
    rd(1, 3'd0, ZEROS, "R9 right got t0"); rd(0, 3'd0, ONES, "R9 left lost t0"); step(); step();

    // R8: left claims t1, right (not pending) writes release, left keeps it
    wr(0, 3'd1, ZEROS); step();
    wr(1, 3'd1, ONES); step();
    rd(0, 3'd1, ZEROS, "R8 left keeps t1"); step(); step();

    // R8: right claims t1 then withdraws; left release leaves t1 free
    wr(1, 3'd1, ZEROS); step();
    wr(1, 3'd1, ONES); step();
    wr(0, 3'd1, ONES); step();
    rd(1, 3'd1, ONES, "R8 withdrawn right sees free"); rd(0, 3'd1, ONES, "R8 left sees free"); step(); step();

    // R7: same-cycle claim on t2, left wins, right pending then receives
    wr(0, 3'd2, ZEROS); wr(1, 3'd2, ZEROS); step();
    rd(0, 3'd2, ZEROS, "R7 left wins t2"); rd(1, 3'd2, ONES, "R7 right loses t2"); step(); step();
    wr(0, 3'd2, ONES); step();
    rd(1, 3'd2, ZEROS, "R7 R9 pending right gets t2"); step(); step();

    // R1: both selects low, a claim must be ignored
    drv(0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, ZEROS); step();
    rd(0, 3'd3, ONES, "R1 illegal claim ignored"); step(); step();
    // R1: read with chip select low gives no valid strobe
    drv(0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, ONES); step();
    check("R1 no valid on illegal read", {31'd0, l_rd_vld}, 32'd0);
    step();
    // R1: semaphore select high, no access
    drv(1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, ZEROS); step();
    rd(1, 3'd3, ONES, "R1 deselected write ignored"); step(); step();

    // R3: claim through lane 8 only; other non-lane bits zero still release
    wr(0, 3'd4, 32'hFFFF_FEFF); step();
    rd(0, 3'd4, ZEROS, "R3 lane8 claim"); step(); step();
    wr(1, 3'd5, 32'h00FF_FFFF); step();
    rd(1, 3'd5, ZEROS, "R3 lane24 claim"); step(); step();
    wr(0, 3'd4, 32'h0101_0101); step();
    rd(0, 3'd4, ONES, "R3 release with only lane bits set"); step(); step();

    // R5: read in same cycle as other port's claim shows old state
    wr(0, 3'd6, ZEROS); rd(1, 3'd6, ONES, "R5 same-cycle read old state"); step();
    rd(1, 3'd6, ONES, "R6 right sees t6 owned"); rd(0, 3'd6, ZEROS, "R5 left t6 next cycle"); step(); step();

    // R2: token 7 still free everywhere
    rd(0, 3'd7, ONES, "R2 left t7 free"); rd(1, 3'd7, ONES, "R2 right t7 free"); step(); step();

    step();
    if (ql.size() != 0 || qr.size() != 0)
      check("R5 pending reads not seen", 32'(ql.size() + qr.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule